// File: doc/BRIEF.md
# Parallel NOR Bus Interface Decoder

This block is the device-side front end of a parallel NOR memory, built as synchronous logic that runs on a fast sampling clock. The four asynchronous control pins (chip enable, output enable, write enable and the reset pin) are synchronised. Chip enable, write enable and the reset pin then pass through a pulse filter, so a pin change counts only once it has held for a set number of samples. Each cycle, the filtered levels are sorted into one of five bus states: reset, standby, output disable, read or write.

For writes, the block forms a write strobe that is active while chip enable and write enable are both low. It takes the address when the strobe starts, which is the later of the two falling edges. It takes the data when the strobe ends, which is the earlier of the two rising edges. It then hands the result downstream as a one-cycle pulse. If output enable goes low during the strobe, the write is dropped and an error pulse is raised instead. If the reset pin is asserted during the strobe, the write is dropped with no pulse at all.

For reads, the block serves data from an 8-word page buffer. The buffer is filled through a simple synchronous array port with one cycle of read latency. A read in the buffered page returns after a short wait. A read outside it refills the whole page first. Reads in the alternate space (extended region or query area) never use the buffer. They do one direct array access instead.

The data bus can run 16 bits wide, or 8 bits wide, where DQ15 becomes the lowest address bit. It is modelled as a value vector plus a per-bit output-enable vector.

Top module: `nor_bus_front`

## Requirements
- R1: `bus_mode_o` gives the bus state of the filtered pins, encoded as 0 reset, 1 standby, 2 output disable, 3 read and 4 write. The priority runs from highest to lowest: reset pin low gives 0; chip enable high gives 1; write enable low gives 4; output enable high gives 2; otherwise the state is 3. After `rst_n` the state is 0, and no output is driven.
- R2: A low pulse on chip enable, write enable or the reset pin that lasts fewer than FILT_LEN sample clocks does not change `bus_mode_o`, and it starts no write. A pulse of FILT_LEN+2 sample clocks does take effect.
- R3: A write takes the address present when the strobe starts. This is the later of the two falling edges of chip enable and write enable. The captured byte address `wr_addr_o` is {addr_i, 0} in 16-bit mode and {addr_i, DQ15} in 8-bit mode. Address changes made after the strobe starts are ignored.
- R4: A write takes `dq_i` as it is when the strobe ends, which is the first of the two rising edges. In 8-bit mode only DQ[7:0] are taken, and `wr_data_o[15:8]` reads 0.
- R5: Each completed write gives exactly one cycle of `wr_valid_o` high, with the address and data on `wr_addr_o` and `wr_data_o`.
- R6: If output enable is low at any point while the strobe is active, the write gives no `wr_valid_o`. It gives exactly one cycle of `wr_err_o` instead.
- R7: In the standby, output disable, reset and write states, `dq_oe_o` is 0. This also holds when chip enable and output enable are both low while the reset pin is low.
- R8: A 16-bit read drives all 16 bits (`dq_oe_o` = 16'hFFFF). The value driven is the array word at `addr_i`, and it appears once `rd_valid_o` is high.
- R9: An 8-bit read drives only DQ[7:0] (`dq_oe_o` = 16'h00FF). DQ15 = 0 selects the low byte of the word at `addr_i`, and DQ15 = 1 selects the high byte. DQ[14:8] are never driven in this mode.
- R10: A read whose address bits above bit 2 match the buffered page issues no array request. It becomes valid in fewer cycles than a read that misses the page.
- R11: A read in the main space that misses the page issues exactly 8 array requests, for the 8 words of that page, and then returns the addressed word.
- R12: A read with `alt_i` = 1 issues exactly one array request, with `arr_alt_o` = 1. It leaves the buffered page unchanged, so the next main-space read in that page issues no request.
- R13: If the reset pin goes low while the strobe is active, the write produces neither `wr_valid_o` nor `wr_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset of the logic |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| rst_pin_n | input | 1 | Device reset pin, active low, asynchronous |
| wide_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus with DQ15 as the lowest address bit |
| alt_i | input | 1 | Read targets the extended region or query area, with no page mode |
| addr_i | input | ADDR_W | Word address pins |
| dq_i | input | 16 | Data pins as seen by the input buffers |
| dq_o | output | 16 | Read data to drive |
| dq_oe_o | output | 16 | Per-bit output enable; 0 means high-Z |
| rd_valid_o | output | 1 | Read data on dq_o is valid |
| bus_mode_o | output | 3 | Decoded bus state (encoding in R1) |
| wr_valid_o | output | 1 | One-cycle pulse for a completed write |
| wr_addr_o | output | ADDR_W+1 | Captured byte address of the write |
| wr_data_o | output | 16 | Captured write data |
| wr_err_o | output | 1 | One-cycle pulse for a write dropped because output enable was low |
| arr_req_o | output | 1 | Array read request |
| arr_addr_o | output | ADDR_W | Array word address |
| arr_alt_o | output | 1 | Array request targets the alternate space |
| arr_rdata_i | input | 16 | Array read data, valid one cycle after the request |

## Verification
The hardest states to reach are the ones inside a write strobe. Here the address and data pins must change between the strobe's start and end. Output enable or the reset pin must also be pulsed while the strobe is still active. The stimulus reaches these states with a write task that takes both edge orders and an optional mid-strobe disturbance. It moves the address after the start, so a capture on the wrong edge shows up as a mismatch. Read coverage comes from random addresses spread over four pages, with alternate-space accesses mixed in. A bench-side model of the buffered page predicts whether each read hits, misses or goes direct. From that it predicts the exact number of array requests each read should issue.

// File: rtl/nor_bus_pkg.sv
// Shared types and constants of the parallel NOR bus front end.
// Assumes a page of eight 16-bit words.
package nor_bus_pkg;

    localparam int DQ_W       = 16;
    localparam int PAGE_BITS  = 3;
    localparam int PAGE_WORDS = 1 << PAGE_BITS;

    typedef enum logic [2:0] {
        BM_RESET   = 3'd0,
        BM_STANDBY = 3'd1,
        BM_OUTDIS  = 3'd2,
        BM_READ    = 3'd3,
        BM_WRITE   = 3'd4
    } bus_mode_t;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_FILL,
        RS_FDRAIN,
        RS_LATCH,
        RS_DIRECT,
        RS_DCAP,
        RS_WAIT,
        RS_DONE
    } rd_state_t;

endpackage

// File: rtl/nor_pin_filter.sv
// Two-flop synchroniser followed by a pulse filter for one control pin.
// The filtered level follows the synchronised pin only after the pin has
// differed from it for LEN consecutive samples; shorter pulses vanish.
// Assumes LEN >= 1; LEN = 1 gives a plain extra register stage.
module nor_pin_filter #(
    parameter int   LEN     = 3,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o
);

    localparam int CW = (LEN < 2) ? 1 : $clog2(LEN);

    logic          s1_q, s2_q, lvl_q;
    logic [CW-1:0] run_q;

    // Synchronise the asynchronous pin into the sampling clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
        end
    end

    // Count how long the pin has disagreed; accept the new level after LEN samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= RST_VAL;
            run_q <= '0;
        end else if (s2_q == lvl_q) begin
            run_q <= '0;
        end else if (run_q == CW'(LEN - 1)) begin
            lvl_q <= s2_q;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign level_o = lvl_q;

endmodule

// File: rtl/nor_write_capture.sv
// Write strobe tracking: the strobe is active while chip enable and write
// enable are both low and the reset pin is high. The address is taken at
// strobe start and the data at strobe end. Output enable low at any time in
// the strobe turns the write into an error pulse; a reset pin assertion
// drops it silently. Assumes the address is stable at the start and the data
// is stable at the end for the filter latency.
module nor_write_capture #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_f,
    input  logic              we_f,
    input  logic              oe_f,
    input  logic              rstp_f,
    input  logic              wide_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       dq_i,
    output logic              wr_valid_o,
    output logic [ADDR_W:0]   wr_addr_o,
    output logic [15:0]       wr_data_o,
    output logic              wr_err_o
);

    logic stb, stb_q, bad_q;

    assign stb = ~ce_f & ~we_f & rstp_f;

    // Track the strobe, latch at its start, and report at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q      <= 1'b0;
            bad_q      <= 1'b0;
            wr_valid_o <= 1'b0;
            wr_err_o   <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
        end else begin
            stb_q      <= stb;
            wr_valid_o <= 1'b0;
            wr_err_o   <= 1'b0;
            if (stb && !stb_q) begin
                wr_addr_o <= {addr_i, (wide_i ? 1'b0 : dq_i[15])};
                bad_q     <= ~oe_f;
            end else if (stb && !oe_f) begin
                bad_q <= 1'b1;
            end
            if (!stb && stb_q && rstp_f) begin
                if (bad_q || !oe_f) begin
                    wr_err_o <= 1'b1;
                end else begin
                    wr_valid_o <= 1'b1;
                    wr_data_o  <= wide_i ? dq_i : {8'h00, dq_i[7:0]};
                end
            end
        end
    end

endmodule

// File: rtl/nor_page_reader.sv
// Read path with an 8-word page buffer. A main-space read in the buffered
// page waits HIT_LAT cycles; a miss refills the page with eight array
// reads (one-cycle array latency) and then waits MISS_LAT cycles. Reads in
// the alternate space do one direct array read and leave the buffer alone.
// Assumes HIT_LAT >= 1 and MISS_LAT >= 1.
module nor_page_reader
    import nor_bus_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int HIT_LAT  = 2,
    parameter int MISS_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic              abort_i,
    input  logic              wide_i,
    input  logic              alt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              bsel_i,
    input  logic [15:0]       arr_rdata_i,
    output logic [15:0]       word_o,
    output logic              bsel_o,
    output logic              wide_o,
    output logic              valid_o,
    output logic              arr_req_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic              arr_alt_o
);

    localparam int TAG_W   = ADDR_W - PAGE_BITS;
    localparam int KEY_W   = ADDR_W + 3;
    localparam int LAT_MAX = (HIT_LAT > MISS_LAT) ? HIT_LAT : MISS_LAT;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    rd_state_t            st_q;
    logic [KEY_W-1:0]     key_now, key_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [PAGE_BITS-1:0] idx_q, cap_idx_q;
    logic                 cap_v_q;
    logic [TAG_W-1:0]     fill_tag_q, tag_q, tag_now;
    logic                 tag_vld_q;
    logic [15:0]          word_q;
    logic [15:0]          pg_mem [PAGE_WORDS];
    logic [ADDR_W-1:0]    req_addr;
    logic                 hit, key_moved;

    assign key_now   = {alt_i, wide_i, addr_i, bsel_i & ~wide_i};
    assign req_addr  = key_q[ADDR_W:1];
    assign tag_now   = addr_i[ADDR_W-1:PAGE_BITS];
    assign hit       = tag_vld_q && (tag_q == tag_now) && !alt_i;
    assign key_moved = (key_now != key_q);

    // Read sequencer: decide hit, refill or direct access and time the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= RS_IDLE;
            key_q      <= '0;
            cnt_q      <= '0;
            idx_q      <= '0;
            cap_v_q    <= 1'b0;
            cap_idx_q  <= '0;
            fill_tag_q <= '0;
            tag_q      <= '0;
            tag_vld_q  <= 1'b0;
            word_q     <= '0;
        end else begin
            cap_v_q <= 1'b0;
            if (abort_i) begin
                st_q <= RS_IDLE;
            end else begin
                case (st_q)
                    RS_IDLE: begin
                        if (rd_en_i) begin
                            key_q <= key_now;
                            if (alt_i) begin
                                st_q <= RS_DIRECT;
                            end else if (hit) begin
                                word_q <= pg_mem[addr_i[PAGE_BITS-1:0]];
                                cnt_q  <= CNT_W'(HIT_LAT - 1);
                                st_q   <= RS_WAIT;
                            end else begin
                                fill_tag_q <= tag_now;
                                tag_vld_q  <= 1'b0;
                                idx_q      <= '0;
                                st_q       <= RS_FILL;
                            end
                        end
                    end
                    RS_FILL: begin
                        cap_v_q   <= 1'b1;
                        cap_idx_q <= idx_q;
                        idx_q     <= idx_q + 1'b1;
                        if (idx_q == PAGE_BITS'(PAGE_WORDS - 1)) begin
                            st_q <= RS_FDRAIN;
                        end
                    end
                    RS_FDRAIN: begin
                        st_q <= RS_LATCH;
                    end
                    RS_LATCH: begin
                        tag_q     <= fill_tag_q;
                        tag_vld_q <= 1'b1;
                        word_q    <= pg_mem[req_addr[PAGE_BITS-1:0]];
                        cnt_q     <= CNT_W'(MISS_LAT - 1);
                        st_q      <= RS_WAIT;
                    end
                    RS_DIRECT: begin
                        st_q <= RS_DCAP;
                    end
                    RS_DCAP: begin
                        word_q <= arr_rdata_i;
                        cnt_q  <= CNT_W'(MISS_LAT - 1);
                        st_q   <= RS_WAIT;
                    end
                    RS_WAIT: begin
                        if (!rd_en_i || key_moved) begin
                            st_q <= RS_IDLE;
                        end else if (cnt_q == '0) begin
                            st_q <= RS_DONE;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    RS_DONE: begin
                        if (!rd_en_i || key_moved) begin
                            st_q <= RS_IDLE;
                        end
                    end
                    default: st_q <= RS_IDLE;
                endcase
            end
        end
    end

    // Page buffer write port: store each array word one cycle after its request.
    always_ff @(posedge clk) begin
        if (cap_v_q) begin
            pg_mem[cap_idx_q] <= arr_rdata_i;
        end
    end

    assign arr_req_o  = (st_q == RS_FILL) || (st_q == RS_DIRECT);
    assign arr_addr_o = (st_q == RS_FILL) ? {fill_tag_q, idx_q} : req_addr;
    assign arr_alt_o  = (st_q == RS_DIRECT) && key_q[KEY_W-1];
    assign word_o     = word_q;
    assign bsel_o     = key_q[0];
    assign wide_o     = key_q[KEY_W-2];
    assign valid_o    = (st_q == RS_DONE);

endmodule

// File: rtl/nor_bus_front.sv
// Top of the parallel NOR bus front end. Filters the control pins, decodes
// the bus state, and joins the write capture and the page read path. Data
// output drive is enabled only in the read state once data is valid.
// Assumes all pins change well apart relative to the sampling clock.
module nor_bus_front
    import nor_bus_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int FILT_LEN = 3,
    parameter int HIT_LAT  = 2,
    parameter int MISS_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              rst_pin_n,
    input  logic              wide_i,
    input  logic              alt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       dq_i,
    output logic [15:0]       dq_o,
    output logic [15:0]       dq_oe_o,
    output logic              rd_valid_o,
    output logic [2:0]        bus_mode_o,
    output logic              wr_valid_o,
    output logic [ADDR_W:0]   wr_addr_o,
    output logic [15:0]       wr_data_o,
    output logic              wr_err_o,
    output logic              arr_req_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic              arr_alt_o,
    input  logic [15:0]       arr_rdata_i
);

    localparam int NPIN = 4;

    logic [NPIN-1:0] pin_raw, pin_f;
    bus_mode_t       mode_d, mode_q;
    logic [15:0]     rd_word;
    logic            rd_bsel, rd_wide, rd_valid;

    assign pin_raw = {rst_pin_n, we_n, oe_n, ce_n};

    // One filter per control pin; output enable needs no glitch rejection.
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        localparam int   L  = (g == 1) ? 1 : FILT_LEN;
        localparam logic RV = (g == 3) ? 1'b0 : 1'b1;
        nor_pin_filter #(.LEN(L), .RST_VAL(RV)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_raw[g]),
            .level_o (pin_f[g])
        );
    end

    // Classify the filtered pins into a bus state by priority.
    always_comb begin
        if (!pin_f[3])      mode_d = BM_RESET;
        else if (pin_f[0])  mode_d = BM_STANDBY;
        else if (!pin_f[2]) mode_d = BM_WRITE;
        else if (pin_f[1])  mode_d = BM_OUTDIS;
        else                mode_d = BM_READ;
    end

    // Register the bus state.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= BM_RESET;
        else        mode_q <= mode_d;
    end

    nor_write_capture #(.ADDR_W(ADDR_W)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_f       (pin_f[0]),
        .we_f       (pin_f[2]),
        .oe_f       (pin_f[1]),
        .rstp_f     (pin_f[3]),
        .wide_i     (wide_i),
        .addr_i     (addr_i),
        .dq_i       (dq_i),
        .wr_valid_o (wr_valid_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .wr_err_o   (wr_err_o)
    );

    nor_page_reader #(.ADDR_W(ADDR_W), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en_i     (mode_q == BM_READ),
        .abort_i     (mode_q == BM_RESET),
        .wide_i      (wide_i),
        .alt_i       (alt_i),
        .addr_i      (addr_i),
        .bsel_i      (dq_i[15]),
        .arr_rdata_i (arr_rdata_i),
        .word_o      (rd_word),
        .bsel_o      (rd_bsel),
        .wide_o      (rd_wide),
        .valid_o     (rd_valid),
        .arr_req_o   (arr_req_o),
        .arr_addr_o  (arr_addr_o),
        .arr_alt_o   (arr_alt_o)
    );

    // Output drive: full word in 16-bit mode, selected byte on the low lane otherwise.
    always_comb begin
        dq_oe_o = '0;
        if (mode_q == BM_READ && rd_valid) begin
            dq_oe_o = rd_wide ? 16'hFFFF : 16'h00FF;
        end
        dq_o = rd_wide ? rd_word : {8'h00, (rd_bsel ? rd_word[15:8] : rd_word[7:0])};
    end

    assign rd_valid_o = rd_valid;
    assign bus_mode_o = mode_q;

endmodule

// File: rtl/nor_bus_front_chk.sv
// Property checker for the NOR bus front end, attached by bind.
module nor_bus_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  bus_mode,
    input logic [15:0] dq_oe,
    input logic        rd_valid,
    input logic        wr_valid,
    input logic        wr_err,
    input logic        arr_req
);

    assert_hiz_off_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != 16'h0000) |-> (bus_mode == 3'd3));

    assert_lane_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == 16'h0000) || (dq_oe == 16'h00FF) || (dq_oe == 16'hFFFF));

    assert_drive_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != 16'h0000) |-> rd_valid);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    assert_err_excludes_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && wr_err));

    assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> !wr_err);

    assert_no_req_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode == 3'd0) |=> !arr_req);

endmodule

bind nor_bus_front nor_bus_front_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_mode (bus_mode_o),
    .dq_oe    (dq_oe_o),
    .rd_valid (rd_valid_o),
    .wr_valid (wr_valid_o),
    .wr_err   (wr_err_o),
    .arr_req  (arr_req_o)
);

// File: tb/sim_nor_bus_front.sv
// Bench for nor_bus_front: directed corner cases plus seeded random reads/writes.
module sim_nor_bus_front;

    localparam int ADDR_W   = 12;
    localparam int FILT_LEN = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rst_pin_n = 1'b1;
    logic              wide = 1'b1, alt = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       dq_in = '0;
    logic [15:0]       dq_o, dq_oe;
    logic              rd_valid, wr_valid, wr_err, arr_req, arr_alt;
    logic [2:0]        bus_mode;
    logic [ADDR_W:0]   wr_addr;
    logic [15:0]       wr_data, arr_rdata = '0;
    logic [ADDR_W-1:0] arr_addr;

    int checks = 0, errors = 0;
    int wr_seen = 0, err_seen = 0, req_seen = 0;
    logic [ADDR_W:0] last_wa = '0;
    logic [15:0]     last_wd = '0;

    // Bench-side page model
    logic [ADDR_W-4:0] m_tag = '0;
    logic              m_vld = 1'b0;
    logic [ADDR_W+2:0] m_key = '0;

    always #4 clk = ~clk;

    nor_bus_front #(.ADDR_W(ADDR_W), .FILT_LEN(FILT_LEN), .HIT_LAT(2), .MISS_LAT(4)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rst_pin_n(rst_pin_n),
        .wide_i(wide), .alt_i(alt), .addr_i(addr), .dq_i(dq_in),
        .dq_o(dq_o), .dq_oe_o(dq_oe), .rd_valid_o(rd_valid), .bus_mode_o(bus_mode),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_err_o(wr_err),
        .arr_req_o(arr_req), .arr_addr_o(arr_addr), .arr_alt_o(arr_alt), .arr_rdata_i(arr_rdata)
    );

    function automatic logic [15:0] mem_f(input logic [ADDR_W-1:0] a, input logic s);
        logic [31:0] p;
        p = 32'(a) * 32'h9E37 + 32'h1234;
        return p[15:0] ^ (s ? 16'hA55A : 16'h0000);
    endfunction

    // Array model with one cycle of read latency, and event counters.
    always @(posedge clk) begin
        if (arr_req) begin
            arr_rdata <= mem_f(arr_addr, arr_alt);
            req_seen = req_seen + 1;
        end
        if (wr_valid) begin
            wr_seen = wr_seen + 1;
            last_wa = wr_addr;
            last_wd = wr_data;
        end
        if (wr_err) err_seen = err_seen + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_mode(input string req, input int exp_mode);
        cyc(14);
        check(bus_mode == 3'(exp_mode), req, "bus mode", bus_mode, exp_mode);
    endtask

    // Drive a read and return data, output enable, latency and array requests.
    task automatic do_read(input logic [ADDR_W-1:0] a, input logic bs, input logic w,
                           input logic s, output logic [15:0] d, output logic [15:0] oe,
                           output int lat, output int reqs);
        int r0;
        @(negedge clk);
        r0 = req_seen;
        addr = a; wide = w; alt = s; dq_in = w ? 16'h0000 : {bs, 15'h0};
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rd_valid && lat < 200);
        d = dq_o; oe = dq_oe; reqs = req_seen - r0;
    endtask

    // Full read check with the bench page model predicting the array traffic.
    task automatic read_chk(input string req, input logic [ADDR_W-1:0] a, input logic bs,
                            input logic w, input logic s, output int lat);
        logic [15:0] d, oe, w16, exp_d;
        int reqs, exp_r;
        logic [ADDR_W+2:0] k;
        k = {s, w, a, bs & ~w};
        if (k == m_key) begin
            a = a ^ 12'h001;
            k = {s, w, a, bs & ~w};
        end
        if (s) exp_r = 1;
        else if (m_vld && m_tag == a[ADDR_W-1:3]) exp_r = 0;
        else exp_r = 8;
        do_read(a, bs, w, s, d, oe, lat, reqs);
        m_key = k;
        if (!s && exp_r == 8) begin m_tag = a[ADDR_W-1:3]; m_vld = 1'b1; end
        w16 = mem_f(a, s);
        exp_d = w ? w16 : {8'h00, (bs ? w16[15:8] : w16[7:0])};
        check(d == exp_d, req, "read data", d, exp_d);
        check(oe == (w ? 16'hFFFF : 16'h00FF), w ? "R8" : "R9", "read drive", oe,
              w ? 16'hFFFF : 16'h00FF);
        check(reqs == exp_r, s ? "R12" : (exp_r == 0 ? "R10" : "R11"), "array requests",
              reqs, exp_r);
    endtask

    task automatic go_idle();
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; alt = 1'b0;
        cyc(14);
    endtask

    // mode: 0 normal, 1 output enable low mid-strobe, 2 reset pin low mid-strobe
    task automatic do_write(input string req, input bit we_first, input bit ce_rise_first,
                            input logic w, input logic [ADDR_W-1:0] a, input logic a1,
                            input logic [15:0] d, input int mode);
        int w0, e0;
        logic [ADDR_W:0] exp_a;
        logic [15:0] exp_d;
        w0 = wr_seen; e0 = err_seen;
        @(negedge clk);
        wide = w; oe_n = 1'b1;
        addr = a ^ 12'h0F0;
        dq_in = {~a1, 15'h1357};
        if (we_first) we_n = 1'b0; else ce_n = 1'b0;
        cyc(8);
        addr = a; dq_in = {a1, 15'h2468};
        cyc(2);
        if (we_first) ce_n = 1'b0; else we_n = 1'b0;
        cyc(12);
        addr = a ^ 12'h5A5; dq_in = {~a1, 15'h7777};
        cyc(4);
        dq_in = d;
        if (mode == 1) begin oe_n = 1'b0; cyc(6); oe_n = 1'b1; end
        if (mode == 2) begin rst_pin_n = 1'b0; cyc(10); end
        cyc(8);
        if (ce_rise_first) ce_n = 1'b1; else we_n = 1'b1;
        cyc(16);
        dq_in = 16'hDEAD;
        ce_n = 1'b1; we_n = 1'b1;
        cyc(4);
        rst_pin_n = 1'b1;
        cyc(14);
        exp_a = {a, (w ? 1'b0 : a1)};
        exp_d = w ? d : {8'h00, d[7:0]};
        if (mode == 0) begin
            check(wr_seen - w0 == 1, "R5", "write pulses", wr_seen - w0, 1);
            check(last_wa == exp_a, "R3", "write address", last_wa, exp_a);
            check(last_wd == exp_d, "R4", "write data", last_wd, exp_d);
            check(err_seen == e0, req, "no error", err_seen - e0, 0);
        end else if (mode == 1) begin
            check(wr_seen == w0, "R6", "write dropped", wr_seen - w0, 0);
            check(err_seen - e0 == 1, "R6", "error pulses", err_seen - e0, 1);
        end else begin
            check(wr_seen == w0, "R13", "write dropped", wr_seen - w0, 0);
            check(err_seen == e0, "R13", "no error", err_seen - e0, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int lat_m, lat_h, bad, seen, dummy;
        void'($urandom(32'd20240611));
        cyc(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(bus_mode == 3'd0, "R1", "mode after reset", bus_mode, 0);
        check(dq_oe == 16'h0, "R1", "drive after reset", dq_oe, 0);
        check(!wr_valid && !arr_req, "R1", "pulses after reset", {wr_valid, arr_req}, 0);

        // R1/R7 state decode and high-Z
        check_mode("R1", 1);
        check(dq_oe == 16'h0, "R7", "standby drive", dq_oe, 0);
        ce_n = 1'b0;
        check_mode("R1", 2);
        check(dq_oe == 16'h0, "R7", "outdis drive", dq_oe, 0);
        we_n = 1'b0;
        check_mode("R1", 4);
        check(dq_oe == 16'h0, "R7", "write-state drive", dq_oe, 0);
        we_n = 1'b1; oe_n = 1'b0; rst_pin_n = 1'b0;
        check_mode("R1", 0);
        check(dq_oe == 16'h0, "R7", "reset drive", dq_oe, 0);
        rst_pin_n = 1'b1;
        check_mode("R1", 3);
        go_idle();
        check(bus_mode == 3'd1, "R1", "back to standby", bus_mode, 1);

        // R2 glitch filter
        bad = 0;
        @(negedge clk); ce_n = 1'b0;
        cyc(FILT_LEN - 1); ce_n = 1'b1;
        repeat (16) begin @(negedge clk); if (bus_mode != 3'd1) bad++; end
        check(bad == 0, "R2", "short chip enable pulse", bad, 0);
        bad = 0;
        @(negedge clk); rst_pin_n = 1'b0;
        cyc(FILT_LEN - 1); rst_pin_n = 1'b1;
        repeat (16) begin @(negedge clk); if (bus_mode != 3'd1) bad++; end
        check(bad == 0, "R2", "short reset pin pulse", bad, 0);
        seen = 0;
        @(negedge clk); ce_n = 1'b0;
        repeat (FILT_LEN + 2) begin @(negedge clk); if (bus_mode == 3'd2) seen = 1; end
        ce_n = 1'b1;
        repeat (16) begin @(negedge clk); if (bus_mode == 3'd2) seen = 1; end
        check(seen == 1, "R2", "long pulse accepted", seen, 1);
        ce_n = 1'b0; cyc(14);
        bad = 0; dummy = wr_seen + err_seen;
        @(negedge clk); we_n = 1'b0;
        cyc(FILT_LEN - 1); we_n = 1'b1;
        repeat (16) begin @(negedge clk); if (bus_mode != 3'd2) bad++; end
        check(bad == 0 && dummy == wr_seen + err_seen, "R2", "short write enable pulse", bad, 0);
        go_idle();

        // Directed writes: both edge orders, both widths, disturbances
        do_write("R3", 1'b1, 1'b1, 1'b1, 12'h3A4, 1'b0, 16'hBEEF, 0);
        do_write("R4", 1'b0, 1'b0, 1'b0, 12'h0C7, 1'b1, 16'h12A5, 0);
        do_write("R6", 1'b1, 1'b0, 1'b1, 12'h111, 1'b0, 16'h0F0F, 1);
        do_write("R13", 1'b0, 1'b1, 1'b1, 12'h222, 1'b0, 16'hF00D, 2);

        // Directed reads: miss then hit in the same page, alternate space leaves page
        read_chk("R11", 12'h2A2, 1'b0, 1'b1, 1'b0, lat_m);
        read_chk("R10", 12'h2A6, 1'b0, 1'b1, 1'b0, lat_h);
        check(lat_h < lat_m, "R10", "hit faster than miss", lat_h, lat_m);
        read_chk("R12", 12'h2A1, 1'b0, 1'b1, 1'b1, dummy);
        read_chk("R12", 12'h2A1, 1'b0, 1'b1, 1'b0, dummy);
        read_chk("R9", 12'h2A3, 1'b1, 1'b0, 1'b0, dummy);
        read_chk("R9", 12'h2A3, 1'b0, 1'b0, 1'b0, dummy);
        go_idle();
        m_key = '1;

        // Random reads over four pages
        for (int i = 0; i < 60; i++) begin
            logic [ADDR_W-1:0] ra;
            ra = {7'h15, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7))};
            read_chk("R8", ra, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     ($urandom_range(0, 7) == 0), dummy);
        end
        go_idle();
        m_key = '1;

        // Random writes
        for (int i = 0; i < 12; i++) begin
            do_write("R5", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 12'($urandom_range(0, 4095)),
                     1'($urandom_range(0, 1)), 16'($urandom_range(0, 65535)), 0);
        end

        report();
        $finish;
    end

endmodule